// File: doc/BRIEF.md
# Invalidate/Update Acknowledge Tracker

This block follows one outstanding invalidate or update request that the processor has placed on the system bus. From the cycle after the request is issued, it holds the pipeline stalled. It keeps the stall until the external agent resolves the request. The agent resolves it with a one-cycle pulse on an active-low acknowledge line or an active-low error line. These pulses may overlap any other bus traffic, including an external request that is in progress at the time.

An external request may also reach the processor while the invalidate or update is still pending. That request's command carries a no-cancel bit:
- If the bit is clear, the pending request is dropped and the causing instruction is flagged for re-execution.
- If the bit is set, the request stays pending and the stall is released while the external request is serviced. When the servicing logic reports that it has finished, the stall comes back.

Acknowledge or error pulses that arrive with nothing outstanding are flagged as protocol violations. All result outputs are single-cycle pulses that are registered one cycle after the event that causes them. The stall output follows the tracker state.

Top module: `ivt_tracker`

## Requirements
- R1: When `issue_i` is high in a clock cycle with no request outstanding, `stall_o` is high from the next cycle. It stays high until the request is terminated.
- R2: A low `ack_n_i` while `stall_o` is high, with `err_n_i` high, gives one cycle of `done_o`=1 with `done_err_o`=0 in the next cycle. `stall_o` falls in that same cycle.
- R3: A low `err_n_i` while a request is outstanding gives one cycle of `done_o`=1 with `done_err_o`=1 in the next cycle. `done_err_o` is never high without `done_o`.
- R4: When `ack_n_i` and `err_n_i` are both low in the same cycle, the completion reports error status (`done_err_o`=1).
- R5: `ext_req_i` with `ext_nocancel_i`=0 (command bit 4 clear) while `stall_o` is high, and with no acknowledge or error, gives one cycle of `reexec_o` in the next cycle. In that cycle `stall_o` is low and `done_o` is low.
- R6: `ext_req_i` with `ext_nocancel_i`=1 (command bit 4 set) while `stall_o` is high drops `stall_o` from the next cycle and gives no `done_o` or `reexec_o`. A later `ext_done_i` pulse brings `stall_o` back from the cycle after it.
- R7: An acknowledge or error pulse that arrives while the external request is being serviced completes the request (`done_o`, with the matching status). `stall_o` does not come back.
- R8: An acknowledge or error pulse with no request outstanding gives one cycle of `proto_err_o` in the next cycle, and no `done_o`.
- R9: When an acknowledge or error arrives in the same cycle as an external request, the completion wins and `reexec_o` stays low.
- R10: While `rst_n` is low, and in the cycle after it is released, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Invalidate/update request issued this cycle |
| ack_n_i | input | 1 | Acknowledge pulse from external agent, active low |
| err_n_i | input | 1 | Error pulse from external agent, active low |
| ext_req_i | input | 1 | External request arrived this cycle |
| ext_nocancel_i | input | 1 | Bit 4 of the external command: 1 = do not cancel |
| ext_done_i | input | 1 | Servicing of the external request finished |
| stall_o | output | 1 | Pipeline stall |
| done_o | output | 1 | Request completed (one-cycle pulse) |
| done_err_o | output | 1 | Completion status, 1 = error; valid with done_o |
| reexec_o | output | 1 | Re-execute the causing instruction (one-cycle pulse) |
| proto_err_o | output | 1 | Stray acknowledge or error (one-cycle pulse) |

## Verification
The bench drives the simultaneous acknowledge-and-error cycle. A design with the priority reversed would report success there. It sends an external request in the same cycle as a completion pulse; a wrong ordering would raise `reexec_o` and lose the completion. It also completes a request while the stall is released for servicing, which catches a design that ignores the agent outside the stalled state and hangs. Finally, it sends stray pulses in idle and a pulse in the very cycle of issue. A design that treats these as completions would produce phantom `done_o` pulses or never flag the violation.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_SVC  = 2'd2
  } ivt_state_e;

  typedef enum logic [1:0] {
    RS_NONE = 2'd0,
    RS_ACK  = 2'd1,
    RS_ERR  = 2'd2
  } ivt_resp_e;
endpackage

// File: rtl/ivt_resp_decode.sv
module ivt_resp_decode #(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic              ack_line,
  input  logic              err_line,
  output ivt_pkg::ivt_resp_e resp
);
  import ivt_pkg::*;

  logic ack_on;
  logic err_on;

  generate
    if (ACTIVE_LOW) begin : g_low
      assign ack_on = ~ack_line;
      assign err_on = ~err_line;
    end else begin : g_high
      assign ack_on = ack_line;
      assign err_on = err_line;
    end
  endgenerate

  // error outranks acknowledge when both lines are active
  always_comb begin
    if (err_on)      resp = RS_ERR;
    else if (ack_on) resp = RS_ACK;
    else             resp = RS_NONE;
  end
endmodule

// File: rtl/ivt_fsm.sv
module ivt_fsm (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issue,
  input  ivt_pkg::ivt_resp_e  resp,
  input  logic                ext_req,
  input  logic                ext_nocancel,
  input  logic                ext_done,
  output ivt_pkg::ivt_state_e state,
  output logic                fin_ok,
  output logic                fin_err,
  output logic                cancel,
  output logic                stray
);
  import ivt_pkg::*;

  ivt_state_e state_d;
  logic       busy;

  assign busy = (state != ST_IDLE);

  always_comb begin
    state_d = state;
    fin_ok  = 1'b0;
    fin_err = 1'b0;
    cancel  = 1'b0;
    stray   = 1'b0;
    if (!busy) begin
      stray = (resp != RS_NONE);
      if (issue) state_d = ST_PEND;
    end else if (resp == RS_ERR) begin
      fin_err = 1'b1;
      state_d = ST_IDLE;
    end else if (resp == RS_ACK) begin
      fin_ok  = 1'b1;
      state_d = ST_IDLE;
    end else if (state == ST_PEND) begin
      if (ext_req) begin
        if (ext_nocancel) begin
          state_d = ST_SVC;
        end else begin
          cancel  = 1'b1;
          state_d = ST_IDLE;
        end
      end
    end else if (ext_done) begin
      state_d = ST_PEND;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/ivt_pulse_reg.sv
module ivt_pulse_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/ivt_tracker.sv
module ivt_tracker #(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue_i,
  input  logic ack_n_i,
  input  logic err_n_i,
  input  logic ext_req_i,
  input  logic ext_nocancel_i,
  input  logic ext_done_i,
  output logic stall_o,
  output logic done_o,
  output logic done_err_o,
  output logic reexec_o,
  output logic proto_err_o
);
  import ivt_pkg::*;

  localparam int NPULSE = 4;

  ivt_resp_e          resp;
  ivt_state_e         state_q;
  logic               fin_ok, fin_err, cancel, stray;
  logic [NPULSE-1:0]  pulse_d, pulse_q;

  ivt_resp_decode #(.ACTIVE_LOW(ACTIVE_LOW)) u_dec (
    .ack_line (ack_n_i),
    .err_line (err_n_i),
    .resp     (resp)
  );

  ivt_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue        (issue_i),
    .resp         (resp),
    .ext_req      (ext_req_i),
    .ext_nocancel (ext_nocancel_i),
    .ext_done     (ext_done_i),
    .state        (state_q),
    .fin_ok       (fin_ok),
    .fin_err      (fin_err),
    .cancel       (cancel),
    .stray        (stray)
  );

  assign pulse_d = {fin_ok | fin_err, fin_err, cancel, stray};

  ivt_pulse_reg #(.W(NPULSE)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pulse_d),
    .q     (pulse_q)
  );

  assign stall_o     = (state_q == ST_PEND);
  assign done_o      = pulse_q[3];
  assign done_err_o  = pulse_q[2];
  assign reexec_o    = pulse_q[1];
  assign proto_err_o = pulse_q[0];
endmodule

// File: rtl/ivt_tracker_chk.sv
module ivt_tracker_chk (
  input logic               clk,
  input logic               rst_n,
  input logic               issue_i,
  input logic               ack_n_i,
  input logic               err_n_i,
  input logic               ext_req_i,
  input logic               ext_nocancel_i,
  input logic               ext_done_i,
  input logic               stall_o,
  input logic               done_o,
  input logic               done_err_o,
  input logic               reexec_o,
  input logic               proto_err_o,
  input ivt_pkg::ivt_state_e state_q
);
  import ivt_pkg::*;

  logic busy;
  assign busy = (state_q != ST_IDLE);

  p_issue_stalls_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && issue_i) |=> stall_o);

  p_ack_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && !ack_n_i && err_n_i) |=> (done_o && !done_err_o && !stall_o));

  p_err_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !err_n_i) |=> (done_o && done_err_o));

  p_status_with_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_err_o |-> done_o);

  p_both_is_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ack_n_i && !err_n_i) |=> done_err_o);

  p_cancel_reexec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && ack_n_i && err_n_i && ext_req_i && !ext_nocancel_i)
      |=> (reexec_o && !stall_o && !done_o));

  p_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SVC && ack_n_i && err_n_i && ext_done_i) |=> stall_o);

  p_svc_complete_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SVC && !ack_n_i) |=> (done_o && !stall_o));

  p_stray_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (!ack_n_i || !err_n_i)) |=> (proto_err_o && !done_o));

  p_done_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ext_req_i && (!ack_n_i || !err_n_i)) |=> (!reexec_o && done_o));

  p_excl_pulses_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, reexec_o, proto_err_o}));
endmodule

bind ivt_tracker ivt_tracker_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .issue_i        (issue_i),
  .ack_n_i        (ack_n_i),
  .err_n_i        (err_n_i),
  .ext_req_i      (ext_req_i),
  .ext_nocancel_i (ext_nocancel_i),
  .ext_done_i     (ext_done_i),
  .stall_o        (stall_o),
  .done_o         (done_o),
  .done_err_o     (done_err_o),
  .reexec_o       (reexec_o),
  .proto_err_o    (proto_err_o),
  .state_q        (state_q)
);

// File: tb/sim_ivt_tracker.sv
`timescale 1ns/1ps
module sim_ivt_tracker;
  logic clk = 1'b0;
  logic rst_n;
  logic issue_i, ack_n_i, err_n_i, ext_req_i, ext_nocancel_i, ext_done_i;
  logic stall_o, done_o, done_err_o, reexec_o, proto_err_o;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ivt_tracker u0 (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .ack_n_i(ack_n_i),
    .err_n_i(err_n_i), .ext_req_i(ext_req_i), .ext_nocancel_i(ext_nocancel_i),
    .ext_done_i(ext_done_i), .stall_o(stall_o), .done_o(done_o),
    .done_err_o(done_err_o), .reexec_o(reexec_o), .proto_err_o(proto_err_o)
  );

  // row: [15:12] requirement, [11:6] {issue,ack_n,err_n,ext_req,nocancel,ext_done},
  //      [4:0] expected after the edge {stall,done,done_err,reexec,proto_err}
  localparam int NV = 29;
  localparam logic [15:0] VEC [NV] = '{
    {4'd1, 6'b111000, 1'b0, 5'b10000},  // R1 issue
    {4'd1, 6'b011000, 1'b0, 5'b10000},  // R1 hold
    {4'd2, 6'b001000, 1'b0, 5'b01000},  // R2 ack
    {4'd2, 6'b011000, 1'b0, 5'b00000},
    {4'd1, 6'b111000, 1'b0, 5'b10000},
    {4'd3, 6'b010000, 1'b0, 5'b01100},  // R3 error
    {4'd1, 6'b111000, 1'b0, 5'b10000},
    {4'd4, 6'b000000, 1'b0, 5'b01100},  // R4 both lines
    {4'd1, 6'b111000, 1'b0, 5'b10000},
    {4'd5, 6'b011100, 1'b0, 5'b00010},  // R5 cancel
    {4'd5, 6'b011000, 1'b0, 5'b00000},
    {4'd1, 6'b111000, 1'b0, 5'b10000},
    {4'd6, 6'b011110, 1'b0, 5'b00000},  // R6 no-cancel
    {4'd6, 6'b011000, 1'b0, 5'b00000},
    {4'd6, 6'b011001, 1'b0, 5'b10000},  // R6 resume
    {4'd2, 6'b001000, 1'b0, 5'b01000},
    {4'd1, 6'b111000, 1'b0, 5'b10000},
    {4'd6, 6'b011110, 1'b0, 5'b00000},
    {4'd7, 6'b001000, 1'b0, 5'b01000},  // R7 ack in service
    {4'd1, 6'b111000, 1'b0, 5'b10000},
    {4'd6, 6'b011110, 1'b0, 5'b00000},
    {4'd7, 6'b010000, 1'b0, 5'b01100},  // R7 error in service
    {4'd8, 6'b001000, 1'b0, 5'b00001},  // R8 stray ack
    {4'd8, 6'b010000, 1'b0, 5'b00001},  // R8 stray error
    {4'd8, 6'b011000, 1'b0, 5'b00000},
    {4'd1, 6'b111000, 1'b0, 5'b10000},
    {4'd9, 6'b001100, 1'b0, 5'b01000},  // R9 ack with cancel
    {4'd1, 6'b111000, 1'b0, 5'b10000},
    {4'd9, 6'b010100, 1'b0, 5'b01100}   // R9 error with cancel
  };

  task automatic check(input int req, input logic [4:0] act, input logic [4:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL R%0d: outputs {stall,done,err,reexec,proto} actual=%b expected=%b",
               req, act, exp_v);
    end
  endtask

  function automatic logic [4:0] outs();
    return {stall_o, done_o, done_err_o, reexec_o, proto_err_o};
  endfunction

  task automatic drive(input logic [5:0] v);
    {issue_i, ack_n_i, err_n_i, ext_req_i, ext_nocancel_i, ext_done_i} = v;
  endtask

  // apply at negedge, sample 5 ns after the following posedge
  task automatic step(input logic [5:0] v);
    @(negedge clk);
    drive(v);
    @(posedge clk);
    #5;
  endtask

  initial begin
    rst_n = 1'b0;
    drive(6'b011000);
    #1;
    check(10, outs(), 5'b00000);  // R10 during reset
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step(6'b011000);
    check(10, outs(), 5'b00000);  // R10 after release

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][11:6]);
      check(int'(VEC[i][15:12]), outs(), VEC[i][4:0]);
    end

    // R8: pulse in the very cycle of issue is stray, request still starts
    step(6'b101000);
    check(8, outs(), 5'b10001);
    step(6'b011000);
    check(1, outs(), 5'b10000);
    // R6: extra external request while servicing does not cancel
    step(6'b011110);
    check(6, outs(), 5'b00000);
    step(6'b011100);
    check(6, outs(), 5'b00000);
    step(6'b011001);
    check(6, outs(), 5'b10000);
    // R10: reset while stalled clears everything
    @(negedge clk);
    drive(6'b011000);
    rst_n = 1'b0;
    #1;
    check(10, outs(), 5'b00000);
    @(negedge clk);
    rst_n = 1'b1;
    step(6'b011000);
    check(10, outs(), 5'b00000);

    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!ended) begin
      ended = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule